// File: doc/BRIEF.md
# Machine Control Register with Cache Policy Decode

This block holds a 32-bit machine control register carrying four live fields: protection enable (bit 0), not-write-through (bit 29), cache disable (bit 30) and paging enable (bit 31). All other positions are tied to zero. Software reaches the register through two write paths:

- a full-width write, which is screened for illegal field combinations;
- a narrow status-word load, which reaches only bits 15:0.

A full write that fails the screen is not committed. Instead the block emits a one-cycle general-protection fault pulse with an error code.

The committed fields are decoded at once, together with the external cacheability inputs, into three live cache controls:

- whether a line read after a miss may be installed;
- whether a CPU write must be driven onto the external bus;
- whether snooped invalidations remove lines.

The block also reports the operating mode derived from the paging and protection bits. The cache array, paging hardware and segmentation logic sit outside and consume these outputs.

Top module: `mcr_cache_ctrl`

## Requirements
- R1: After a synchronous active-low reset the register reads 0x4000_0000 (cache disable set, all else 0), the fault output is 0, the mode is 00 and no line fill is permitted.
- R2: A legal full write commits on the next clock edge. Bits outside positions 31, 30, 29 and 0 read back as 0 whatever was written.
- R3: A full write with bit 31 = 1 and bit 0 = 0 is refused. In the cycle after the write edge, the fault output is 1 for exactly one cycle and the error code reads 0x0000.
- R4: A full write with bit 30 = 0 and bit 29 = 1 is refused and raises the same one-cycle fault, with error code ERR_CACHE (default 0x0000). The committed register never holds bit 30 = 0 together with bit 29 = 1.
- R5: A refused write leaves every register bit unchanged. While the fault output is 0, the error code output is 0x0000.
- R6: A status-word load writes only bits 15:0 (masked to the defined bits) and leaves bits 31:16 unchanged. The status-word read port returns bits 15:0 only. When a full write and a status-word load occur in the same cycle, the full write takes priority.
- R7: A line fill is permitted only when bit 30 = 0, the active-low cache-enable input is 0 and the selected page cache-disable bit is 0. The select encoding is 00 page-table entry, 01 directory entry, 10 third control register bit, and 11 forces uncacheable.
- R8: A write request is driven to the bus when bit 29 = 0. When bit 29 = 1, it is driven only if the write misses the cache.
- R9: Invalidation is enabled exactly when bit 29 = 0. A snoop hit removes the line only while invalidation is enabled.
- R10: The mode output equals {bit 31, bit 0}: 00 real, 01 protected, 11 paged protected. The value 10 appears only if a status-word load clears bit 0 while bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_full | input | 1 | Full-width register write strobe |
| wr_data | input | 32 | Full-width write value |
| msw_ld | input | 1 | Status-word load strobe |
| msw_data | input | 16 | Status-word load value |
| creg_q | output | 32 | Committed register value |
| msw_q | output | 16 | Status-word read (bits 15:0) |
| gp_fault | output | 1 | One-cycle general-protection fault pulse |
| gp_code | output | 16 | Error code, valid with gp_fault |
| ken_n | input | 1 | Active-low external cache enable for the current fill |
| pcd_sel | input | 2 | Source select for the page cache-disable bit |
| pte_pcd | input | 1 | Page cache-disable from the page-table entry |
| pde_pcd | input | 1 | Page cache-disable from the directory entry |
| cr3_pcd | input | 1 | Page cache-disable from the third control register |
| wr_req | input | 1 | CPU write request |
| wr_hit | input | 1 | CPU write hits in the cache |
| snoop_hit | input | 1 | Snooped invalidate address hits in the cache |
| line_fill | output | 1 | Missed line may be installed |
| bus_write | output | 1 | Write must be driven to the bus |
| inval_en | output | 1 | Invalidation cycles enabled |
| drop_line | output | 1 | Remove the snooped line |
| mode | output | 2 | Operating mode {paging, protection} |

## Verification
The hardest state to reach is mode 10, because the full-write path screens it out. The stimulus first commits a legal value with paging and protection both set. It then issues a status-word load with bit 0 clear, which bypasses the screen. The reference model follows the same rules, so the bench also checks that the cache-field invariant survives this path. Simultaneous full writes and status-word loads, including refused full writes combined with a load, are driven in both directed and random phases. These confirm that a refused full write still blocks the load in that cycle.

// File: rtl/mcr_pkg.sv
// Package: shared field positions, mode and source encodings, check verdict type.
package mcr_pkg;
    localparam int XW     = 32;
    localparam int MSW_W  = 16;
    localparam int PG_B   = 31;
    localparam int CD_B   = 30;
    localparam int NW_B   = 29;
    localparam int PE_B   = 0;
    localparam int CODE_W = 16;

    typedef enum logic [1:0] {
        MODE_REAL  = 2'b00,
        MODE_PROT  = 2'b01,
        MODE_UNDEF = 2'b10,
        MODE_PAGED = 2'b11
    } op_mode_e;

    typedef enum logic [1:0] {
        SRC_PTE  = 2'b00,
        SRC_PDE  = 2'b01,
        SRC_CR3  = 2'b10,
        SRC_NONE = 2'b11
    } pcd_src_e;

    typedef struct packed {
        logic              refuse;
        logic [CODE_W-1:0] code;
    } verdict_t;
endpackage

// File: rtl/mcr_write_check.sv
// mcr_write_check: screens a full-width write value for illegal field pairs.
// Assumes: purely combinational; paging check has precedence over cache check
// when both are violated (only the error code differs).
module mcr_write_check
    import mcr_pkg::*;
#(
    parameter logic [CODE_W-1:0] ERR_PAGING = '0,
    parameter logic [CODE_W-1:0] ERR_CACHE  = '0
) (
    input  logic [XW-1:0] wdata,
    output verdict_t      verdict
);
    logic paging_bad;
    logic cache_bad;

    // Flag each illegal combination separately.
    always_comb begin
        paging_bad = wdata[PG_B] & ~wdata[PE_B];
        cache_bad  = ~wdata[CD_B] & wdata[NW_B];
    end

    // Merge into a verdict with the matching error code.
    always_comb begin
        verdict.refuse = paging_bad | cache_bad;
        if (paging_bad)
            verdict.code = ERR_PAGING;
        else if (cache_bad)
            verdict.code = ERR_CACHE;
        else
            verdict.code = '0;
    end
endmodule

// File: rtl/mcr_store.sv
// mcr_store: the register bits plus the fault pulse and error code registers.
// Assumes: refuse/code come from the checker for wdata in the same cycle;
// a full write outranks a status-word load; only DEF_MASK bits are stored.
module mcr_store
    import mcr_pkg::*;
#(
    parameter logic [XW-1:0] DEF_MASK  = 32'hE000_0001,
    parameter logic [XW-1:0] RESET_VAL = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_full,
    input  logic [XW-1:0]     wdata,
    input  logic              refuse,
    input  logic [CODE_W-1:0] code_in,
    input  logic              msw_ld,
    input  logic [MSW_W-1:0]  msw_data,
    output logic [XW-1:0]     creg_q,
    output logic              fault,
    output logic [CODE_W-1:0] code_q
);
    logic commit_full;
    logic take_msw;

    // Decide which path, if any, updates the register this cycle.
    always_comb begin
        commit_full = wr_full & ~refuse;
        take_msw    = msw_ld & ~wr_full;
    end

    for (genvar i = 0; i < XW; i++) begin : g_bit
        if (DEF_MASK[i]) begin : g_live
            logic q;
            // Per-bit storage: full write, then status-word load (low half only).
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= RESET_VAL[i];
                else if (commit_full)
                    q <= wdata[i];
                else if (take_msw && (i < MSW_W))
                    q <= msw_data[i % MSW_W];
            end
            assign creg_q[i] = q;
        end else begin : g_tied
            assign creg_q[i] = 1'b0;
        end
    end

    // Fault pulse and error code, registered one cycle after the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault  <= 1'b0;
            code_q <= '0;
        end else begin
            fault  <= wr_full & refuse;
            code_q <= (wr_full & refuse) ? code_in : '0;
        end
    end

    assert_msw_keeps_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msw_ld && !wr_full) |=> creg_q[XW-1:MSW_W] == $past(creg_q[XW-1:MSW_W]));

    assert_fault_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !$past(wr_full, 1)) |-> 1'b0 ) else $error("fault without write");

    assert_code_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> code_q == '0);
endmodule

// File: rtl/mcr_cache_policy.sv
// mcr_cache_policy: decodes committed fields and external inputs into cache
// controls and the operating mode. Assumes: combinational, inputs are live.
module mcr_cache_policy
    import mcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg,
    input  logic       cd,
    input  logic       nw,
    input  logic       pe,
    input  logic       ken_n,
    input  logic [1:0] pcd_sel,
    input  logic       pte_pcd,
    input  logic       pde_pcd,
    input  logic       cr3_pcd,
    input  logic       wr_req,
    input  logic       wr_hit,
    input  logic       snoop_hit,
    output logic       line_fill,
    output logic       bus_write,
    output logic       inval_en,
    output logic       drop_line,
    output op_mode_e   mode
);
    logic page_uc;

    // Pick the applicable page cache-disable source; unused code is uncacheable.
    always_comb begin
        unique case (pcd_src_e'(pcd_sel))
            SRC_PTE:  page_uc = pte_pcd;
            SRC_PDE:  page_uc = pde_pcd;
            SRC_CR3:  page_uc = cr3_pcd;
            default:  page_uc = 1'b1;
        endcase
    end

    // Fill, write-out and invalidate decisions.
    always_comb begin
        line_fill = ~cd & ~ken_n & ~page_uc;
        bus_write = wr_req & (~nw | ~wr_hit);
        inval_en  = ~nw;
        drop_line = snoop_hit & inval_en;
    end

    // Operating mode from paging and protection bits.
    always_comb mode = op_mode_e'({pg, pe});

    assert_no_fill_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cd || ken_n) |-> !line_fill);

    assert_hit_absorbed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nw && wr_hit) |-> !bus_write);

    assert_drop_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop_line |-> (snoop_hit && !nw));
endmodule

// File: rtl/mcr_cache_ctrl.sv
// mcr_cache_ctrl: top of the machine control register with cache policy.
// Assumes: single clock, synchronous active-low reset; the status-word path
// is not screened; outputs line_fill/bus_write/inval_en/drop_line/mode are
// combinational from the committed register and the live inputs.
module mcr_cache_ctrl
    import mcr_pkg::*;
#(
    parameter logic [XW-1:0]     DEF_MASK   = 32'hE000_0001,
    parameter logic [XW-1:0]     RESET_VAL  = 32'h4000_0000,
    parameter logic [CODE_W-1:0] ERR_PAGING = '0,
    parameter logic [CODE_W-1:0] ERR_CACHE  = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_full,
    input  logic [31:0] wr_data,
    input  logic        msw_ld,
    input  logic [15:0] msw_data,
    output logic [31:0] creg_q,
    output logic [15:0] msw_q,
    output logic        gp_fault,
    output logic [15:0] gp_code,
    input  logic        ken_n,
    input  logic [1:0]  pcd_sel,
    input  logic        pte_pcd,
    input  logic        pde_pcd,
    input  logic        cr3_pcd,
    input  logic        wr_req,
    input  logic        wr_hit,
    input  logic        snoop_hit,
    output logic        line_fill,
    output logic        bus_write,
    output logic        inval_en,
    output logic        drop_line,
    output logic [1:0]  mode
);
    localparam logic [XW-1:0] WMASK = DEF_MASK;

    verdict_t        verdict;
    logic [XW-1:0]   wmasked;
    op_mode_e        mode_e;

    // Drop undefined positions before storing.
    always_comb wmasked = wr_data & WMASK;

    mcr_write_check #(
        .ERR_PAGING (ERR_PAGING),
        .ERR_CACHE  (ERR_CACHE)
    ) u_check (
        .wdata   (wr_data),
        .verdict (verdict)
    );

    mcr_store #(
        .DEF_MASK  (DEF_MASK),
        .RESET_VAL (RESET_VAL)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_full  (wr_full),
        .wdata    (wmasked),
        .refuse   (verdict.refuse),
        .code_in  (verdict.code),
        .msw_ld   (msw_ld),
        .msw_data (msw_data),
        .creg_q   (creg_q),
        .fault    (gp_fault),
        .code_q   (gp_code)
    );

    mcr_cache_policy u_policy (
        .clk       (clk),
        .rst_n     (rst_n),
        .pg        (creg_q[PG_B]),
        .cd        (creg_q[CD_B]),
        .nw        (creg_q[NW_B]),
        .pe        (creg_q[PE_B]),
        .ken_n     (ken_n),
        .pcd_sel   (pcd_sel),
        .pte_pcd   (pte_pcd),
        .pde_pcd   (pde_pcd),
        .cr3_pcd   (cr3_pcd),
        .wr_req    (wr_req),
        .wr_hit    (wr_hit),
        .snoop_hit (snoop_hit),
        .line_fill (line_fill),
        .bus_write (bus_write),
        .inval_en  (inval_en),
        .drop_line (drop_line),
        .mode      (mode_e)
    );

    // Status-word read and mode port.
    always_comb begin
        msw_q = creg_q[MSW_W-1:0];
        mode  = mode_e;
    end

    assert_refused_unchanged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gp_fault |-> creg_q == $past(creg_q));

    assert_no_cd0_nw1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!creg_q[CD_B] && creg_q[NW_B]));

    assert_paging_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && wr_data[PG_B] && !wr_data[PE_B]) |=> gp_fault);

    assert_mode_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_full && !gp_fault && wr_data[PG_B] == wr_data[PE_B]) |=>
            (gp_fault || mode[1] == mode[0]));
endmodule

// File: tb/sim_mcr_cache_ctrl.sv
`timescale 1ns/1ps
module sim_mcr_cache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_full = 1'b0;
    logic [31:0] wr_data = '0;
    logic        msw_ld = 1'b0;
    logic [15:0] msw_data = '0;
    logic [31:0] creg_q;
    logic [15:0] msw_q;
    logic        gp_fault;
    logic [15:0] gp_code;
    logic        ken_n = 1'b1;
    logic [1:0]  pcd_sel = 2'b00;
    logic        pte_pcd = 1'b0, pde_pcd = 1'b0, cr3_pcd = 1'b0;
    logic        wr_req = 1'b0, wr_hit = 1'b0, snoop_hit = 1'b0;
    logic        line_fill, bus_write, inval_en, drop_line;
    logic [1:0]  mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mcr_cache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_full(wr_full), .wr_data(wr_data),
        .msw_ld(msw_ld), .msw_data(msw_data), .creg_q(creg_q), .msw_q(msw_q),
        .gp_fault(gp_fault), .gp_code(gp_code), .ken_n(ken_n), .pcd_sel(pcd_sel),
        .pte_pcd(pte_pcd), .pde_pcd(pde_pcd), .cr3_pcd(cr3_pcd), .wr_req(wr_req),
        .wr_hit(wr_hit), .snoop_hit(snoop_hit), .line_fill(line_fill),
        .bus_write(bus_write), .inval_en(inval_en), .drop_line(drop_line), .mode(mode)
    );

    // Reference model state, written from the requirement text.
    logic [31:0] m_reg;
    logic        m_flt;
    logic [15:0] m_code;
    localparam logic [31:0] LIVE = 32'h8000_0000 | 32'h4000_0000 | 32'h2000_0000 | 32'h1;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg  <= 32'h4000_0000;
            m_flt  <= 1'b0;
            m_code <= 16'h0;
        end else begin
            m_flt  <= 1'b0;
            m_code <= 16'h0;
            if (wr_full) begin
                if ((wr_data[31] && !wr_data[0]) || (!wr_data[30] && wr_data[29])) begin
                    m_flt  <= 1'b1;
                    m_code <= 16'h0;
                end else begin
                    m_reg <= wr_data & LIVE;
                end
            end else if (msw_ld) begin
                m_reg[15:0] <= msw_data & LIVE[15:0];
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every observable output against the model.
    task automatic compare_all();
        logic uc;
        logic e_fill, e_bus, e_inv;
        case (pcd_sel)
            2'b00: uc = pte_pcd;
            2'b01: uc = pde_pcd;
            2'b10: uc = cr3_pcd;
            default: uc = 1'b1;
        endcase
        e_fill = !m_reg[30] && !ken_n && !uc;
        e_inv  = !m_reg[29];
        e_bus  = wr_req && (!m_reg[29] || !wr_hit);
        chk("R2 R5 register", creg_q, m_reg);
        chk("R6 status word", {16'h0, msw_q}, {16'h0, m_reg[15:0]});
        chk("R3 R4 fault", {31'h0, gp_fault}, {31'h0, m_flt});
        chk("R3 R5 code", {16'h0, gp_code}, {16'h0, m_code});
        chk("R7 line fill", {31'h0, line_fill}, {31'h0, e_fill});
        chk("R8 bus write", {31'h0, bus_write}, {31'h0, e_bus});
        chk("R9 inval", {31'h0, inval_en}, {31'h0, e_inv});
        chk("R9 drop", {31'h0, drop_line}, {31'h0, snoop_hit && e_inv});
        chk("R10 mode", {30'h0, mode}, {30'h0, m_reg[31], m_reg[0]});
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wr_full = 0; msw_ld = 0;
    endtask

    task automatic full_wr(input logic [31:0] d);
        wr_full = 1; wr_data = d; msw_ld = 0;
        cyc(); idle();
    endtask

    task automatic msw_wr(input logic [15:0] d);
        msw_ld = 1; msw_data = d; wr_full = 0;
        cyc(); idle();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        // R1: reset state checked explicitly.
        chk("R1 reset register", creg_q, 32'h4000_0000);
        chk("R1 reset fault", {31'h0, gp_fault}, 32'h0);
        chk("R1 reset mode", {30'h0, mode}, 32'h0);
        ken_n = 0;
        cyc();
        chk("R1 no fill after reset", {31'h0, line_fill}, 32'h0);

        // R2: legal writes, undefined bits dropped.
        full_wr(32'h0000_0001); cyc();
        chk("R2 protected mode", creg_q, 32'h0000_0001);
        full_wr(32'hFFFF_FFFF); cyc();
        chk("R2 masked readback", creg_q, 32'hE000_0001);

        // R3: paging without protection refused.
        full_wr(32'h8000_0000);
        chk("R3 fault pulse", {31'h0, gp_fault}, 32'h1);
        chk("R3 code zero", {16'h0, gp_code}, 32'h0);
        cyc();
        chk("R3 pulse one cycle", {31'h0, gp_fault}, 32'h0);
        chk("R5 unchanged after refuse", creg_q, 32'hE000_0001);

        // R4: cache enabled with no-write-through refused.
        full_wr(32'h2000_0001);
        chk("R4 fault pulse", {31'h0, gp_fault}, 32'h1);
        cyc();

        // R7/R8/R9: cache on, sweep selects and write/snoop inputs.
        full_wr(32'h0000_0001); cyc();
        for (int s = 0; s < 4; s++) begin
            pcd_sel = s[1:0];
            pte_pcd = 0; pde_pcd = 1; cr3_pcd = 0;
            wr_req = 1; wr_hit = 1; snoop_hit = 1;
            cyc();
        end
        full_wr(32'h6000_0001);
        wr_req = 1; wr_hit = 1; cyc();
        chk("R8 hit absorbed", {31'h0, bus_write}, 32'h0);
        wr_hit = 0; cyc();
        chk("R8 miss goes out", {31'h0, bus_write}, 32'h1);

        // R10 hard case: paging set, then status word clears protection.
        full_wr(32'hC000_0001); cyc();
        msw_wr(16'hFFFE); cyc();
        chk("R10 undefined mode via status word", {30'h0, mode}, 32'h2);
        chk("R6 high half kept", creg_q, 32'hC000_0000);

        // R6: full write wins over simultaneous load, refused or not.
        wr_full = 1; wr_data = 32'h4000_0001; msw_ld = 1; msw_data = 16'h0000;
        cyc(); idle(); cyc();
        chk("R6 full write priority", creg_q, 32'h4000_0001);
        wr_full = 1; wr_data = 32'h8000_0000; msw_ld = 1; msw_data = 16'h0000;
        cyc(); idle(); cyc();
        chk("R6 refused write blocks load", creg_q, 32'h4000_0001);

        // Random phase, compared every cycle.
        for (int n = 0; n < 3000; n++) begin
            wr_full   = ($urandom_range(0, 3) == 0);
            wr_data   = $urandom;
            msw_ld    = ($urandom_range(0, 3) == 0);
            msw_data  = 16'($urandom);
            ken_n     = 1'($urandom);
            pcd_sel   = 2'($urandom);
            pte_pcd   = 1'($urandom);
            pde_pcd   = 1'($urandom);
            cr3_pcd   = 1'($urandom);
            wr_req    = 1'($urandom);
            wr_hit    = 1'($urandom);
            snoop_hit = 1'($urandom);
            cyc();
        end
        idle();
        cyc();
        finish_up();
    end
endmodule